// File: doc/BRIEF.md
# Two-Channel Up/Down Compare Output Stage

This block sits beside an external up/down counter and turns its count into two independent output levels. Each cycle it sees the counter value, the direction of counting, the counter's peak value and a flag that says the counter is at zero. Each channel holds a compare value. When the counter counts up through that value, the channel's output goes to its active level. When the counter counts down through it, the output goes back to inactive. The result is a centre-aligned pulse whose width is set by the compare value.

A compare value is loaded through a per-channel strobe into a staging register. It reaches the working compare register only in a cycle where the counter is at zero, so a new value never takes effect in the middle of a count period. Some compare values have a special meaning. A value of all zeros holds the output active. A value of all ones holds it inactive. A value at or above the peak freezes the output. Each channel also has a sticky hit flag that records qualifying matches. A polarity input per channel selects whether the active level is high or low.

Top module: `ud_cmp_out`

## Requirements
- R1: In a cycle with `cnt_up`=1 where `cnt_val` equals the channel's working compare value, and that value is neither all zeros nor all ones and is below `cnt_peak`, the channel's logical level becomes active and its hit flag becomes 1 on the next clock edge.
- R2: The same match with `cnt_up`=0 makes the logical level inactive and sets the hit flag on the next edge.
- R3: While the working compare value is all zeros, the level is forced active whatever the count or direction. When a zero-count transfer replaces that all-zeros value with a non-zero one, the level goes inactive at that same edge.
- R4: While the working compare value is all ones, the level is forced inactive, and no count value sets the hit flag.
- R5: A non-zero working compare value at or above `cnt_peak` never changes the level and never sets the hit flag, even when the count equals it.
- R6: `wave_o[i]` is the logical level XOR `act_low[i]`. With `act_low`=0 the active level is high; with `act_low`=1 it is low. A change of `act_low` shows on the output without waiting for a clock edge.
- R7: `ld_stb[i]` writes `ld_val` slice i (bits i*W upward) into the staging register. The working compare register takes the staging value only at an edge where `cnt_at_zero`=1. If a load and a transfer fall in the same cycle, the transfer moves the staging value as it was before the load.
- R8: A hit flag stays set until `hit_clr[i]` is pulsed. If a new qualifying match and a clear arrive in the same cycle, the set wins.
- R9: The channels are independent. A load, clear, polarity setting or match on one channel has no effect on the other.
- R10: After reset, both logical levels are inactive, both working and staging compare values are all ones, and both hit flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | W | Current counter value |
| cnt_up | input | 1 | 1 while the counter counts up, 0 while it counts down |
| cnt_peak | input | W | Counter peak value |
| cnt_at_zero | input | 1 | High in a cycle where the counter is at zero; triggers the staging-to-working transfer |
| ld_stb | input | NCH | Per-channel load strobe for the staging register |
| ld_val | input | NCH*W | Load data, W bits per channel |
| act_low | input | NCH | Polarity select; 1 makes the active level low |
| hit_clr | input | NCH | Per-channel hit flag clear |
| wave_o | output | NCH | Channel output levels |
| hit_flag | output | NCH | Sticky hit flags |

## Verification
The bench builds the block with W=8 and NCH=2. With an 8-bit count, the all-ones value (0xFF), a compare value equal to the peak, and the counter's own top value can all be reached in a few cycles. The two channels use opposite polarities so that any cross-talk or polarity slip shows at once. The sequence covers a load and a transfer in the same cycle, a set racing a clear, and a working value moving from all zeros to non-zero.

// File: rtl/ud_cmp_pkg.sv
package ud_cmp_pkg;

    // Action on the logical level chosen for one cycle
    typedef enum logic [1:0] {
        LV_HOLD = 2'd0,
        LV_SET  = 2'd1,
        LV_CLR  = 2'd2
    } lvl_act_e;

    // Priority: forced-active, forced-inactive, out-of-range hold, match
    function automatic lvl_act_e pick_action(
        input logic is_zero,
        input logic is_max,
        input logic in_range,
        input logic eq,
        input logic up
    );
        if (is_zero)
            return LV_SET;
        else if (is_max)
            return LV_CLR;
        else if (!in_range)
            return LV_HOLD;
        else if (eq)
            return up ? LV_SET : LV_CLR;
        else
            return LV_HOLD;
    endfunction

endpackage

// File: rtl/ud_cmp_decode.sv
module ud_cmp_decode #(
    parameter int W = 16
) (
    input  logic [W-1:0] cmp_v,
    input  logic [W-1:0] cnt_v,
    input  logic [W-1:0] peak_v,
    output logic         is_zero,
    output logic         is_max,
    output logic         in_range,
    output logic         eq
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_comb begin
        is_zero  = (cmp_v == '0);
        is_max   = (cmp_v == ALL_ONES);
        in_range = (cmp_v < peak_v);
        eq       = (cmp_v == cnt_v);
    end
endmodule

// File: rtl/ud_cmp_chan.sv
module ud_cmp_chan
    import ud_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_up,
    input  logic [W-1:0] cnt_peak,
    input  logic         cnt_at_zero,
    input  logic         ld_stb,
    input  logic [W-1:0] ld_val,
    input  logic         act_low,
    input  logic         hit_clr,
    output logic         wave_o,
    output logic         hit_flag
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] stage;
        logic [W-1:0] work;
        logic         lvl;
        logic         flag;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic     is_zero, is_max, in_range, eq;
    logic     hit;
    lvl_act_e act;

    ud_cmp_decode #(.W(W)) u_dec (
        .cmp_v    (st_q.work),
        .cnt_v    (cnt_val),
        .peak_v   (cnt_peak),
        .is_zero  (is_zero),
        .is_max   (is_max),
        .in_range (in_range),
        .eq       (eq)
    );

    always_comb begin
        st_d = st_q;
        hit  = !is_zero && !is_max && in_range && eq;
        act  = pick_action(is_zero, is_max, in_range, eq, cnt_up);

        // staging register load
        if (ld_stb)
            st_d.stage = ld_val;

        // logical level
        unique case (act)
            LV_SET:  st_d.lvl = 1'b1;
            LV_CLR:  st_d.lvl = 1'b0;
            default: st_d.lvl = st_q.lvl;
        endcase

        // zero-count transfer; leaving the all-zeros value releases the level
        if (cnt_at_zero) begin
            st_d.work = st_q.stage;
            if (is_zero && (st_q.stage != '0))
                st_d.lvl = 1'b0;
        end

        // sticky flag, set wins over clear
        if (hit)
            st_d.flag = 1'b1;
        else if (hit_clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage <= ALL_ONES;
            st_q.work  <= ALL_ONES;
            st_q.lvl   <= 1'b0;
            st_q.flag  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_o   = st_q.lvl ^ act_low;
    assign hit_flag = st_q.flag;

    // R1: up-count match sets level and flag
    a_r1_up_match: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cnt_up && !(is_zero && cnt_at_zero)) |=> (st_q.lvl && st_q.flag));
    // R2: down-count match clears level, sets flag
    a_r2_down_match: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cnt_up) |=> (!st_q.lvl && st_q.flag));
    // R3: all-zeros value holds level active
    a_r3_zero_active: assert property (@(posedge clk) disable iff (!rst_n)
        (is_zero && !cnt_at_zero) |=> st_q.lvl);
    // R3: leaving all-zeros releases level
    a_r3_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
        (is_zero && cnt_at_zero && (st_q.stage != '0)) |=> !st_q.lvl);
    // R4: all-ones value holds level inactive
    a_r4_max_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        is_max |=> !st_q.lvl);
    // R5: out-of-range value freezes level
    a_r5_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_zero && !is_max && !in_range) |=> (st_q.lvl == $past(st_q.lvl)));
    // R5: out-of-range value never sets the flag
    a_r5_range_noflag: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_zero && !in_range && !st_q.flag) |=> !st_q.flag);
    // R7: transfer copies staging value present before the edge
    a_r7_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_at_zero |=> (st_q.work == $past(st_q.stage)));
    // R7: no transfer keeps working value
    a_r7_work_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_at_zero |=> $stable(st_q.work));
    // R8: flag holds until cleared
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !hit_clr) |=> st_q.flag);
endmodule

// File: rtl/ud_cmp_out.sv
module ud_cmp_out #(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     cnt_val,
    input  logic             cnt_up,
    input  logic [W-1:0]     cnt_peak,
    input  logic             cnt_at_zero,
    input  logic [NCH-1:0]   ld_stb,
    input  logic [NCH*W-1:0] ld_val,
    input  logic [NCH-1:0]   act_low,
    input  logic [NCH-1:0]   hit_clr,
    output logic [NCH-1:0]   wave_o,
    output logic [NCH-1:0]   hit_flag
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ud_cmp_chan #(.W(W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .cnt_val     (cnt_val),
            .cnt_up      (cnt_up),
            .cnt_peak    (cnt_peak),
            .cnt_at_zero (cnt_at_zero),
            .ld_stb      (ld_stb[i]),
            .ld_val      (ld_val[i*W +: W]),
            .act_low     (act_low[i]),
            .hit_clr     (hit_clr[i]),
            .wave_o      (wave_o[i]),
            .hit_flag    (hit_flag[i])
        );
    end
endmodule

// File: tb/ud_cmp_out_test.sv
module ud_cmp_out_test;
    localparam int W   = 8;
    localparam int NCH = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     cnt_val = '0;
    logic             cnt_up = 1'b1;
    logic [W-1:0]     cnt_peak = 8'd200;
    logic             cnt_at_zero = 1'b0;
    logic [NCH-1:0]   ld_stb = '0;
    logic [NCH*W-1:0] ld_val = '0;
    logic [NCH-1:0]   act_low = 2'b10;
    logic [NCH-1:0]   hit_clr = '0;
    logic [NCH-1:0]   wave_o;
    logic [NCH-1:0]   hit_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] wave;
        logic [1:0] flag;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    ud_cmp_out #(.W(W), .NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .cnt_peak(cnt_peak), .cnt_at_zero(cnt_at_zero), .ld_stb(ld_stb),
        .ld_val(ld_val), .act_low(act_low), .hit_clr(hit_clr),
        .wave_o(wave_o), .hit_flag(hit_flag)
    );

    // monitor: compare one expected item per edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (wave_o !== e.wave || hit_flag !== e.flag) begin
                n_fail++;
                $display("FAIL %s: wave=%b flag=%b expected wave=%b flag=%b",
                         e.tag, wave_o, hit_flag, e.wave, e.flag);
            end
        end
    end

    // driver: inputs already set at a negedge; queue the expectation and step
    task automatic tick(input string tag, input logic [1:0] ew, input logic [1:0] ef);
        exp_t e;
        e.wave = ew; e.flag = ef; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        ld_stb = '0;
        hit_clr = '0;
        cnt_at_zero = 1'b0;
    endtask

    task automatic set_cnt(input logic [W-1:0] v, input logic up);
        cnt_val = v;
        cnt_up  = up;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state (ch1 active-low so its inactive level is high)
        n_run++;
        if (wave_o !== 2'b10 || hit_flag !== 2'b00) begin
            n_fail++;
            $display("FAIL R10: wave=%b flag=%b expected wave=10 flag=00", wave_o, hit_flag);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R10: working values start all ones, so count 0xFF sets nothing
        set_cnt(8'hFF, 1'b1);
        tick("R10 all-ones after reset", 2'b10, 2'b00);
        // R7: a load alone does not reach the working register
        ld_stb = 2'b11; ld_val = {8'd100, 8'd50}; set_cnt(8'd50, 1'b1);
        tick("R7 load without transfer", 2'b10, 2'b00);
        set_cnt(8'd0, 1'b1); cnt_at_zero = 1'b1;
        tick("R7 transfer at zero", 2'b10, 2'b00);
        // R1: up matches
        set_cnt(8'd50, 1'b1);
        tick("R1 ch0 up match", 2'b11, 2'b01);
        set_cnt(8'd100, 1'b1);
        tick("R1 R6 R9 ch1 up match active-low", 2'b01, 2'b11);
        set_cnt(8'd150, 1'b1);
        tick("R1 no match holds", 2'b01, 2'b11);
        // R8: clear
        set_cnt(8'd151, 1'b1); hit_clr = 2'b11;
        tick("R8 clear both flags", 2'b01, 2'b00);
        // R2: down matches
        set_cnt(8'd100, 1'b0);
        tick("R2 ch1 down match", 2'b11, 2'b10);
        set_cnt(8'd50, 1'b0); hit_clr = 2'b10;
        tick("R2 R8 ch0 down match, ch1 cleared", 2'b10, 2'b01);
        // R8: set wins over clear
        set_cnt(8'd50, 1'b1); hit_clr = 2'b01;
        tick("R8 set beats clear", 2'b11, 2'b01);
        // R5 / R3 setup: ch0 at peak, ch1 all zeros
        ld_stb = 2'b11; ld_val = {8'd0, 8'd200}; set_cnt(8'd60, 1'b1); hit_clr = 2'b11;
        tick("R8 R9 load and clear", 2'b11, 2'b00);
        set_cnt(8'd0, 1'b1); cnt_at_zero = 1'b1;
        tick("R7 second transfer", 2'b11, 2'b00);
        set_cnt(8'd200, 1'b1);
        tick("R5 R3 peak reached up", 2'b01, 2'b00);
        set_cnt(8'd200, 1'b0);
        tick("R5 peak reached down", 2'b01, 2'b00);
        // R3: all zeros holds regardless of count
        ld_stb = 2'b10; ld_val = {8'd30, 8'd0}; set_cnt(8'd10, 1'b0);
        tick("R3 zero value forced active", 2'b01, 2'b00);
        set_cnt(8'd0, 1'b1); cnt_at_zero = 1'b1;
        tick("R3 leaving zero releases", 2'b11, 2'b00);
        // R7: load and transfer together moves the old staging value
        ld_stb = 2'b01; ld_val = {8'd30, 8'hFF}; set_cnt(8'd0, 1'b1); cnt_at_zero = 1'b1;
        tick("R7 same-cycle load and transfer", 2'b11, 2'b00);
        set_cnt(8'd0, 1'b1); cnt_at_zero = 1'b1;
        tick("R7 all-ones moved in", 2'b11, 2'b00);
        // R4: all ones forces inactive, no flag
        set_cnt(8'd5, 1'b1);
        tick("R4 all-ones forces inactive", 2'b10, 2'b00);
        set_cnt(8'hFF, 1'b1);
        tick("R4 count equals all-ones", 2'b10, 2'b00);
        // R6: polarity swap is combinational
        act_low = 2'b01; set_cnt(8'd7, 1'b1);
        tick("R6 polarity swap", 2'b01, 2'b00);
        set_cnt(8'd30, 1'b1);
        tick("R1 R6 R9 ch1 active-high match", 2'b11, 2'b10);

        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule